// File: doc/BRIEF.md
# Next-Instruction Operand Field Substitution Unit

This unit lets a processor core reach registers indirectly without any pointer registers in hardware. A special "alter fields" operation reads a D operand that holds two pointer fields. It arms a one-shot substitution: the next instruction word the core fetches has its destination-field and source-field replaced by those two pointers before it goes on to the decoder. Only that one instruction is affected. The words fetched after it pass through unchanged.

In the same operation, each of the two pointers held in the D operand is stepped on its own, under control bits carried in the S operand. A pointer can go up by one, go down by one, or stay where it is. The stepped value is handed back to the core to be written into the D register. A loop can therefore walk two arrays by issuing the operation once before each access. The substituted fields are always the pointer values from before the step. If the operation's condition is false, the operation does nothing: it arms nothing and writes nothing back.

Top module: `field_subst_unit`

## Requirements
- R1: While reset (`rstN` low) is asserted and in the first cycle after it, no substitution is pending, so `issuedWord` equals `fetchWord`, and `wbValid` is 0.
- R2: While a substitution is pending, `issuedWord[17:9]` carries the armed D pointer and `issuedWord[8:0]` carries the armed S pointer. Bits 31:18 always come from `fetchWord`.
- R3: A pending substitution is used by exactly one fetch, namely the first cycle in which `fetchValid` is 1. Words fetched after that one pass through unchanged.
- R4: Cycles in which `fetchValid` is 0 do not consume a pending substitution.
- R5: An operation with `opValid=1` and `opCond=1` arms a substitution from the next cycle on. The armed D pointer is `opD[17:9]` and the armed S pointer is `opD[8:0]`, both taken before any step is applied.
- R6: `opS[1:0]` steps the D pointer and `opS[3:2]` steps the S pointer. The code 01 adds 1, 10 subtracts 1, and 00 or 11 holds. Both pointers wrap modulo 512, so 511+1 gives 0 and 0-1 gives 511.
- R7: One cycle after an operation whose condition is true, `wbValid` is 1. `wbData` is `opD` with the two stepped pointers in bits 17:0 and bits 31:18 unchanged. In every other cycle `wbValid` is 0.
- R8: An operation whose condition is false arms nothing, produces no write-back, and leaves a substitution that is already pending untouched.
- R9: If a fetch and an operation fall in the same cycle, the fetch sees the old pending state and consumes it. The new arming still takes effect from the next cycle. Two operations in a row therefore work in order: the second operation's own word is rewritten by the first, and the second then arms for the word after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetched word is taken by the core this cycle |
| fetchWord | input | 32 | Fetched instruction word |
| opValid | input | 1 | The alter-fields operation executes this cycle |
| opCond | input | 1 | The operation's condition is met |
| opD | input | 32 | D operand value (pointer pair) |
| opS | input | 32 | S operand value (step controls in bits 3:0) |
| issuedWord | output | 32 | Fetched word after field substitution |
| wbValid | output | 1 | Write the D register this cycle |
| wbData | output | 32 | Value to write back into the D register |

## Verification
The bench targets pointers at 0 and 511 under every step code, so that a design which failed to wrap, or which swapped the two control pairs, returns a wrong write-back. It checks that the substituted fields are the values from before the step; a design that rewrote with the stepped values would fail there. It holds a substitution pending across idle cycles and then fetches twice. This catches a design that drops the substitution early or keeps it for a second word. It also issues back-to-back and same-cycle fetch/operation pairs, and operations whose condition is false. These expose a wrong priority between arming and consuming, and a false condition that still disturbs the pending state.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic arm;      // latch pointers, start a pending substitution
    logic consume;  // a pending substitution is used by this fetch
    logic wbLoad;   // register the stepped pointer pair for write-back
  } fsuStrobes_t;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_INC   = 2'b01,
    STEP_DEC   = 2'b10,
    STEP_HOLDX = 2'b11
  } stepCode_t;

endpackage

// File: rtl/fsu_ctrl.sv
module fsu_ctrl
  import fsu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fetchValid,
  input  logic        opValid,
  input  logic        opCond,
  output fsuStrobes_t strobes,
  output logic        pending,
  output logic        wbValid
);

  logic pendingQ;
  logic wbValidQ;
  logic opFires;

  assign opFires = opValid && opCond;

  always_comb begin
    strobes.arm     = opFires;
    strobes.consume = fetchValid && pendingQ;
    strobes.wbLoad  = opFires;
  end

  // Arming wins over consumption: a fetch in the same cycle uses the old state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      wbValidQ <= 1'b0;
    end else begin
      wbValidQ <= opFires;
      if (strobes.arm)          pendingQ <= 1'b1;
      else if (strobes.consume) pendingQ <= 1'b0;
    end
  end

  assign pending = pendingQ;
  assign wbValid = wbValidQ;

endmodule

// File: rtl/fsu_datapath.sv
module fsu_datapath
  import fsu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PTR_W  = 9,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsuStrobes_t       strobes,
  input  logic              pending,
  input  logic [WORD_W-1:0] fetchWord,
  input  logic [WORD_W-1:0] opD,
  input  logic [WORD_W-1:0] opS,
  output logic [WORD_W-1:0] issuedWord,
  output logic [WORD_W-1:0] wbData
);

  localparam int NUM_PTR  = 2;
  localparam int FIELDS_W = NUM_PTR * PTR_W;
  localparam int UPPER_W  = WORD_W - FIELDS_W;

  // Field index 0 is the S pointer (low bits), index 1 is the D pointer
  logic [FIELDS_W-1:0] armedQ;
  logic [FIELDS_W-1:0] stepped;
  logic [WORD_W-1:0]   wbDataQ;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] ptr,
                                               input logic [STEP_W-1:0] code);
    case (stepCode_t'(code))
      STEP_INC: stepPtr = ptr + PTR_W'(1);
      STEP_DEC: stepPtr = ptr - PTR_W'(1);
      default:  stepPtr = ptr;
    endcase
  endfunction

  // D pointer takes the lowest control pair, S pointer the next one
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_step
    localparam int CTRL_LO = (NUM_PTR - 1 - i) * STEP_W;
    assign stepped[i*PTR_W +: PTR_W] =
      stepPtr(opD[i*PTR_W +: PTR_W], opS[CTRL_LO +: STEP_W]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ  <= '0;
      wbDataQ <= '0;
    end else begin
      if (strobes.arm)    armedQ  <= opD[FIELDS_W-1:0];
      if (strobes.wbLoad) wbDataQ <= {opD[WORD_W-1:FIELDS_W], stepped};
    end
  end

  assign issuedWord = pending ? {fetchWord[WORD_W-1:FIELDS_W], armedQ} : fetchWord;
  assign wbData     = wbDataQ;

  logic [UPPER_W-1:0] unusedS;
  assign unusedS = opS[WORD_W-1:FIELDS_W];

endmodule

// File: rtl/field_subst_unit.sv
module field_subst_unit
  import fsu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PTR_W  = 9,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [WORD_W-1:0] fetchWord,
  input  logic              opValid,
  input  logic              opCond,
  input  logic [WORD_W-1:0] opD,
  input  logic [WORD_W-1:0] opS,
  output logic [WORD_W-1:0] issuedWord,
  output logic              wbValid,
  output logic [WORD_W-1:0] wbData
);

  fsuStrobes_t strobes;
  logic        pending;

  fsu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .opValid    (opValid),
    .opCond     (opCond),
    .strobes    (strobes),
    .pending    (pending),
    .wbValid    (wbValid)
  );

  fsu_datapath #(
    .WORD_W (WORD_W),
    .PTR_W  (PTR_W),
    .STEP_W (STEP_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pending    (pending),
    .fetchWord  (fetchWord),
    .opD        (opD),
    .opS        (opS),
    .issuedWord (issuedWord),
    .wbData     (wbData)
  );

endmodule

// File: rtl/field_subst_unit_chk.sv
module field_subst_unit_chk #(
  parameter int WORD_W = 32,
  parameter int PTR_W  = 9,
  parameter int STEP_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchValid,
  input logic [WORD_W-1:0] fetchWord,
  input logic              opValid,
  input logic              opCond,
  input logic [WORD_W-1:0] opD,
  input logic [WORD_W-1:0] opS,
  input logic [WORD_W-1:0] issuedWord,
  input logic              wbValid,
  input logic [WORD_W-1:0] wbData
);

  localparam int FW = 2 * PTR_W;

  p_upper_passthru_r2: assert property (@(posedge clk) disable iff (!rstN)
    issuedWord[WORD_W-1:FW] == fetchWord[WORD_W-1:FW]);

  p_single_use_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(fetchValid && !(opValid && opCond)) |-> issuedWord == fetchWord);

  p_armed_preupdate_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && opCond) |-> issuedWord[FW-1:0] == $past(opD[FW-1:0]));

  p_inc_dptr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && $past(opS[STEP_W-1:0]) == 2'b01)
      |-> wbData[FW-1:PTR_W] == PTR_W'($past(opD[FW-1:PTR_W]) + PTR_W'(1)));

  p_wb_follows_op_r7: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(opValid && opCond));

  p_wb_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> wbData[WORD_W-1:FW] == $past(opD[WORD_W-1:FW]));

  p_cond_false_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && !opCond) |-> !wbValid);

endmodule

bind field_subst_unit field_subst_unit_chk #(
  .WORD_W (WORD_W),
  .PTR_W  (PTR_W),
  .STEP_W (STEP_W)
) u_chk (.*);

// File: tb/tb_field_subst_unit.sv
module tb_field_subst_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fetchValid;
  logic [31:0] fetchWord;
  logic        opValid;
  logic        opCond;
  logic [31:0] opD;
  logic [31:0] opS;
  logic [31:0] issuedWord;
  logic        wbValid;
  logic [31:0] wbData;

  int vectors = 0;
  int misses  = 0;

  // reference model state
  bit          mPend;
  int          mDp, mSp;
  bit          mWbV;
  logic [31:0] mWb;

  always #4 clk = ~clk;  // 125 MHz

  field_subst_unit dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchWord(fetchWord),
    .opValid(opValid), .opCond(opCond), .opD(opD), .opS(opS),
    .issuedWord(issuedWord), .wbValid(wbValid), .wbData(wbData)
  );

  function automatic int stepRef(int p, int code);
    if (code == 1) return (p + 1) % 512;
    if (code == 2) return (p + 511) % 512;
    return p;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive, compare before edge, advance model
  task automatic cyc(bit fv, logic [31:0] fw, bit ov, bit oc,
                     logic [31:0] d, logic [31:0] s, string req);
    logic [31:0] expIss;
    fetchValid = fv; fetchWord = fw; opValid = ov; opCond = oc; opD = d; opS = s;
    #2;
    expIss = mPend ? {fw[31:18], mDp[8:0], mSp[8:0]} : fw;
    check({req, mPend ? " R2 issued" : " R3 issued"}, issuedWord, expIss);
    check({req, " R7 wbValid"}, {31'b0, wbValid}, {31'b0, mWbV});
    if (mWbV) check({req, " R7 wbData"}, wbData, mWb);
    @(posedge clk);
    if (!rstN) begin
      mPend = 0; mWbV = 0;
    end else begin
      mWbV = ov && oc;
      if (ov && oc) begin
        mWb = {d[31:18], 9'(stepRef(int'(d[17:9]), int'(s[1:0]))),
                         9'(stepRef(int'(d[8:0]), int'(s[3:2])))};
        mPend = 1; mDp = int'(d[17:9]); mSp = int'(d[8:0]);
      end else if (fv) mPend = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle(string req);
    cyc(0, $urandom, 0, 0, $urandom, $urandom, req);
  endtask

  function automatic logic [31:0] pack(int hi, int dp, int sp);
    return {14'(hi), 9'(dp), 9'(sp)};
  endfunction

  initial begin : watchdog
    #1000000;
    misses++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rstN = 0; mPend = 0; mWbV = 0; mWb = 0; mDp = 0; mSp = 0;
    fetchValid = 0; fetchWord = 0; opValid = 0; opCond = 0; opD = 0; opS = 0;
    @(negedge clk);
    // R1: reset, even with an operation applied
    cyc(1, 32'hDEAD_BEEF, 1, 1, 32'h1234_5678, 32'h5, "R1");
    cyc(0, 32'hCAFE_F00D, 0, 0, 0, 0, "R1");
    rstN = 1;
    cyc(1, 32'h0F0F_0F0F, 0, 0, 0, 0, "R1");

    // R5/R2: arm and use
    cyc(0, 0, 1, 1, pack(3, 100, 200), 32'h0, "R5");
    cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R5");
    cyc(1, 32'hAAAA_5555, 0, 0, 0, 0, "R3");

    // R4: idle fetch cycles do not consume
    cyc(0, 0, 1, 1, pack(0, 7, 9), 32'h0, "R4");
    idle("R4"); idle("R4"); idle("R4");
    cyc(1, 32'h1357_9BDF, 0, 0, 0, 0, "R4");
    cyc(1, 32'h2468_ACE0, 0, 0, 0, 0, "R3");

    // R6: every step code at both wrap points
    for (int c = 0; c < 16; c++) begin
      cyc(0, 0, 1, 1, pack(c, 511, 0), 32'(c), "R6");
      cyc(1, 32'h0, 0, 0, 0, 0, "R6");
      cyc(0, 0, 1, 1, pack(c, 0, 511), 32'(c), "R6");
      cyc(1, 32'h0, 0, 0, 0, 0, "R6");
    end

    // R8: false condition leaves pending state alone
    cyc(0, 0, 1, 1, pack(1, 44, 55), 32'h5, "R8");
    cyc(0, 0, 1, 0, pack(2, 66, 77), 32'h5, "R8");
    cyc(1, 32'h8000_0001, 1, 0, pack(2, 1, 2), 32'h6, "R8");
    cyc(1, 32'h8000_0002, 0, 0, 0, 0, "R8");

    // R9: back-to-back operations, fetch and arm in same cycle
    cyc(0, 0, 1, 1, pack(5, 10, 20), 32'h5, "R9");
    cyc(1, 32'h1111_1111, 1, 1, pack(6, 30, 40), 32'hA, "R9");
    cyc(1, 32'h2222_2222, 1, 1, pack(7, 50, 60), 32'h0, "R9");
    cyc(1, 32'h3333_3333, 0, 0, 0, 0, "R9");
    cyc(1, 32'h4444_4444, 0, 0, 0, 0, "R9");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      cyc($urandom_range(0, 1), $urandom, ($urandom_range(0, 3) == 0),
          $urandom_range(0, 1), $urandom, $urandom, "Rmix");
    end

    // reset mid-pending returns to idle (R1)
    cyc(0, 0, 1, 1, pack(1, 2, 3), 32'h0, "R1");
    rstN = 0;
    idle("R1");
    rstN = 1;
    cyc(1, 32'h7777_0000, 0, 0, 0, 0, "R1");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule